// File: doc/BRIEF.md
# External Interrupt Input Controller

This block takes six external interrupt request pins and one non-maskable interrupt pin, brings them into the clock domain, and turns them into qualified requests for a CPU interrupt unit. A 16-bit control register, written and read through a simple synchronous port, gives each request pin its own detection mode: falling edge, rising edge or low level. Edge-detected requests are held as pending flags until a per-pin clear strobe removes them. Level-detected requests follow the pin.

The four lowest pins can instead be read together as one 4-bit priority code. The block then reports the highest active priority on a 4-bit request level output. Independent pins take fixed levels, and the highest pin has the highest level. A mask-all control suppresses every request while the NMI pin is low. The NMI request is latched on a falling edge of its pin. It can be masked by a block-bit input from the CPU and, when mask-all is set, by a standby input.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The control register resets to 0x4000 on `rst`. It reads back the last value written, and asserting `standby` leaves its contents unchanged.
- R2: Pin i is set by mode field bits [2i+1:2i]: 00 = falling edge, 01 = rising edge, 10 = low level, 11 = low level.
- R3: In an edge mode, a matching pin transition sets that pin's pending flag within four clock cycles. The flag stays set after the pin returns until the pin's `clr_irq` bit is pulsed.
- R4: In a level mode, a pin's pending flag is 1 exactly while the synchronized pin is low. It is not latched, and `clr_irq` does not affect it.
- R5: When control bit 14 is 1, pins 3..0 form a code v, with pin 3 as the MSB. v = 15 means no request; any other v requests level 15 − v. Pending flags 3..0 read 0 in this mode.
- R6: When control bit 14 is 0, `req_level` equals 8 + i for the highest-numbered pending pin i, and is 0 when no pin is pending.
- R7: In encoded mode, pins 5 and 4 still take part, and `req_level` is the larger of the encoded level and their fixed levels.
- R8: While control bit 15 is 1 and the synchronized NMI pin is low, `req_level` is 0. The pending flags are unaffected.
- R9: A falling edge on `nmi_pin` latches an NMI pending state until `clr_nmi` is pulsed. `nmi_req` shows that state unless `blk_bit` is 1 and control bit 13 is 0.
- R10: While `standby` is 1 and control bit 15 is 1, `nmi_req` is 0.
- R11: Control bit 12 is readable and writable, and its value has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| irq_pin | input | 6 | External interrupt request pins |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| blk_bit | input | 1 | CPU block bit |
| standby | input | 1 | Standby state indication |
| clr_irq | input | 6 | Per-pin clear strobe for edge pending flags |
| clr_nmi | input | 1 | Clear strobe for NMI pending state |
| irq_pend | output | 6 | Per-pin pending flags |
| req_level | output | 4 | Highest active request level |
| nmi_req | output | 1 | Qualified NMI request |

## Verification
The hardest case to reach from the ports is a pending edge flag that must survive a mode change. A flag set in falling-edge mode has to stay set after the field is rewritten to rising edge. The same flag must vanish when the pin is switched to level or encoded mode. The stimulus reaches these states by interleaving random control register writes with random pin toggles and clear pulses. The NMI pin, block bit and standby are toggled in the same streams, so the mask-all and NMI gating meet many pending patterns. Directed steps first cover each encoded boundary (v = 15 and v = 0) and each masking combination.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
package eirq_pkg;

    localparam int CFG_W   = 16;
    localparam int LVL_W   = 4;
    localparam int BASE_LV = 8;
    localparam logic [CFG_W-1:0] CFG_RST = 16'h4000;

    typedef enum logic [1:0] {
        DET_FALL    = 2'b00,
        DET_RISE    = 2'b01,
        DET_LOW     = 2'b10,
        DET_LOW_ALT = 2'b11
    } det_mode_e;

    typedef struct packed {
        logic        mask_all;
        logic        enc_mode;
        logic        nmi_blk_ok;
        logic        spare;
        logic [11:0] modes;
    } cfg_t;

    function automatic logic mode_is_level(det_mode_e m);
        return m[1];
    endfunction

    function automatic logic [LVL_W-1:0] pin_level(int idx);
        return LVL_W'(BASE_LV + idx);
    endfunction

    // Code of all ones means idle; otherwise level is the inverted code.
    function automatic logic [LVL_W-1:0] enc_to_level(logic [LVL_W-1:0] v);
        return (v == '1) ? '0 : ~v;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
module eirq_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    // Idle level of all pins is high; reset to that so no false edge appears.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            cur_q  <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= din;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/eirq_pin_det.sv
`timescale 1ns/1ps
module eirq_pin_det
    import eirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cur,
    input  logic      prev,
    input  det_mode_e mode,
    input  logic      force_off,
    input  logic      clr,
    output logic      pend
);
    logic hit;
    logic lvl_mode;
    logic latch_q;

    assign lvl_mode = mode_is_level(mode);

    always_comb begin
        unique case (mode)
            DET_FALL: hit = prev & ~cur;
            DET_RISE: hit = ~prev & cur;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || force_off || lvl_mode) begin
            latch_q <= 1'b0;
        end else if (hit) begin
            latch_q <= 1'b1;
        end else if (clr) begin
            latch_q <= 1'b0;
        end
    end

    always_comb begin
        if (force_off)
            pend = 1'b0;
        else if (lvl_mode)
            pend = ~cur;
        else
            pend = latch_q;
    end
endmodule

// File: rtl/eirq_prio.sv
`timescale 1ns/1ps
module eirq_prio
    import eirq_pkg::*;
#(
    parameter int N = 6
) (
    input  logic [N-1:0]     pend,
    input  logic             enc_en,
    input  logic [LVL_W-1:0] enc_val,
    input  logic             mask,
    output logic [LVL_W-1:0] level
);
    logic [LVL_W-1:0] best;

    always_comb begin
        best = enc_en ? enc_to_level(enc_val) : '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (pin_level(i) > best))
                best = pin_level(i);
        end
        level = mask ? '0 : best;
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_IRQ  = 6,
    parameter int ENC_PINS = LVL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic [NUM_IRQ-1:0] irq_pin,
    input  logic               nmi_pin,
    input  logic               blk_bit,
    input  logic               standby,
    input  logic [NUM_IRQ-1:0] clr_irq,
    input  logic               clr_nmi,
    output logic [NUM_IRQ-1:0] irq_pend,
    output logic [LVL_W-1:0]   req_level,
    output logic               nmi_req
);
    localparam int SYNC_W = NUM_IRQ + 1;

    cfg_t              cfg_q;
    logic [SYNC_W-1:0] s_cur;
    logic [SYNC_W-1:0] s_prev;
    logic              nmi_sync;
    logic              nmi_pend;
    logic              mask_now;
    logic              nmi_blocked;
    logic              nmi_sleep;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= cfg_t'(CFG_RST);
        else if (cfg_we)
            cfg_q <= cfg_t'(cfg_wdata);
    end
    assign cfg_rdata = cfg_q;

    eirq_sync #(.W(SYNC_W)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({nmi_pin, irq_pin}),
        .cur  (s_cur),
        .prev (s_prev)
    );
    assign nmi_sync = s_cur[NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_pin
        logic off;
        if (g < ENC_PINS) begin : g_enc
            assign off = cfg_q.enc_mode;
        end else begin : g_ind
            assign off = 1'b0;
        end
        eirq_pin_det u_det (
            .clk       (clk),
            .rst       (rst),
            .cur       (s_cur[g]),
            .prev      (s_prev[g]),
            .mode      (det_mode_e'(cfg_q.modes[2*g +: 2])),
            .force_off (off),
            .clr       (clr_irq[g]),
            .pend      (irq_pend[g])
        );
    end

    eirq_pin_det u_nmi_det (
        .clk       (clk),
        .rst       (rst),
        .cur       (nmi_sync),
        .prev      (s_prev[NUM_IRQ]),
        .mode      (DET_FALL),
        .force_off (1'b0),
        .clr       (clr_nmi),
        .pend      (nmi_pend)
    );

    assign nmi_blocked = blk_bit & ~cfg_q.nmi_blk_ok;
    assign nmi_sleep   = standby & cfg_q.mask_all;
    assign nmi_req     = nmi_pend & ~nmi_blocked & ~nmi_sleep;
    assign mask_now    = cfg_q.mask_all & ~nmi_sync;

    eirq_prio #(.N(NUM_IRQ)) u_prio (
        .pend    (irq_pend),
        .enc_en  (cfg_q.enc_mode),
        .enc_val (s_cur[LVL_W-1:0]),
        .mask    (mask_now),
        .level   (req_level)
    );
endmodule

// File: rtl/ext_irq_ctrl_sva.sv
`timescale 1ns/1ps
module ext_irq_ctrl_sva (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [15:0] cfg_rdata,
    input logic [5:0]  irq_pend,
    input logic [3:0]  req_level,
    input logic        nmi_req,
    input logic        blk_bit,
    input logic        standby,
    input logic        nmi_s
);
    a_r1_reset_value: assert property (@(posedge clk)
        $fell(rst) |-> cfg_rdata == 16'h4000);

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_rdata));

    a_r5_enc_flags_low: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[14] |-> irq_pend[3:0] == 4'b0000);

    a_r6_level_needs_pend: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[14] && req_level != 4'd0) |-> irq_pend != 6'd0);

    a_r8_mask_all: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[15] && !nmi_s) |-> req_level == 4'd0);

    a_r9_nmi_block: assert property (@(posedge clk) disable iff (rst)
        (blk_bit && !cfg_rdata[13]) |-> !nmi_req);

    a_r10_nmi_standby: assert property (@(posedge clk) disable iff (rst)
        (standby && cfg_rdata[15]) |-> !nmi_req);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .irq_pend  (irq_pend),
    .req_level (req_level),
    .nmi_req   (nmi_req),
    .blk_bit   (blk_bit),
    .standby   (standby),
    .nmi_s     (nmi_sync)
);

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [5:0]  irq_pin = '1;
    logic        nmi_pin = 1'b1;
    logic        blk_bit = 1'b0;
    logic        standby = 1'b0;
    logic [5:0]  clr_irq = '0;
    logic        clr_nmi = 1'b0;
    logic [5:0]  irq_pend;
    logic [3:0]  req_level;
    logic        nmi_req;

    int n_chk = 0;
    int n_fail = 0;

    // bench-side model state
    logic [15:0] m_cfg = 16'h4000;
    logic [5:0]  m_pins = '1;
    logic        m_nmi = 1'b1;
    logic [5:0]  m_lat = '0;
    logic        m_nlat = 1'b0;

    always #2 clk = ~clk;

    ext_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
        .blk_bit(blk_bit), .standby(standby), .clr_irq(clr_irq),
        .clr_nmi(clr_nmi), .irq_pend(irq_pend), .req_level(req_level),
        .nmi_req(nmi_req)
    );

    function automatic logic [1:0] mode_of(int i);
        return m_cfg[2*i +: 2];
    endfunction

    function automatic logic forced(int i);
        return m_cfg[14] && (i < 4);
    endfunction

    function automatic logic [5:0] exp_pend();
        logic [5:0] p;
        for (int i = 0; i < 6; i++) begin
            if (forced(i))         p[i] = 1'b0;
            else if (mode_of(i)[1]) p[i] = ~m_pins[i];
            else                    p[i] = m_lat[i];
        end
        return p;
    endfunction

    function automatic logic [3:0] exp_level();
        logic [5:0] p;
        logic [3:0] lv;
        p = exp_pend();
        lv = 4'd0;
        if (m_cfg[15] && !m_nmi) return 4'd0;
        if (m_cfg[14] && m_pins[3:0] != 4'hF) lv = 4'd15 - m_pins[3:0];
        for (int i = 0; i < 6; i++)
            if (p[i] && 4'(8 + i) > lv) lv = 4'(8 + i);
        return lv;
    endfunction

    function automatic logic exp_nmi();
        return m_nlat && !(blk_bit && !m_cfg[13]) && !(standby && m_cfg[15]);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " cfg"},   32'(cfg_rdata), 32'(m_cfg));
        check({tag, " pend"},  32'(irq_pend),  32'(exp_pend()));
        check({tag, " level"}, 32'(req_level), 32'(exp_level()));
        check({tag, " nmi"},   32'(nmi_req),   32'(exp_nmi()));
    endtask

    task automatic set_pins(logic [5:0] p, logic n);
        for (int i = 0; i < 6; i++) begin
            if (!forced(i) && !mode_of(i)[1]) begin
                if (mode_of(i) == 2'b00 && m_pins[i] && !p[i]) m_lat[i] = 1'b1;
                if (mode_of(i) == 2'b01 && !m_pins[i] && p[i]) m_lat[i] = 1'b1;
            end
        end
        if (m_nmi && !n) m_nlat = 1'b1;
        m_pins = p;
        m_nmi = n;
        @(negedge clk);
        irq_pin = p;
        nmi_pin = n;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [15:0] d);
        m_cfg = d;
        for (int i = 0; i < 6; i++)
            if (forced(i) || mode_of(i)[1]) m_lat[i] = 1'b0;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_clr(logic [5:0] m, logic n);
        for (int i = 0; i < 6; i++) if (m[i]) m_lat[i] = 1'b0;
        if (n) m_nlat = 1'b0;
        @(negedge clk);
        clr_irq = m;
        clr_nmi = n;
        @(negedge clk);
        clr_irq = '0;
        clr_nmi = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset value
        check("R1 reset cfg", 32'(cfg_rdata), 32'h4000);
        check_all("R1 reset");

        // R5: encoded code 1010 -> level 5
        set_pins(6'b111010, 1'b1);
        check("R5 enc level", 32'(req_level), 32'd5);
        check("R5 enc flags", 32'(irq_pend[3:0]), 32'd0);
        // R7: code 0 plus pin5 falling -> 15
        set_pins(6'b010000, 1'b1);
        check("R7 enc vs pin5", 32'(req_level), 32'd15);
        // R5 idle code, R7 pin5 latched alone -> 13
        set_pins(6'b111111, 1'b1);
        check("R7 pin5 only", 32'(req_level), 32'd13);
        pulse_clr(6'b100000, 1'b0);
        check("R5 idle code", 32'(req_level), 32'd0);

        // R3 R6: independent, all falling
        wr_cfg(16'h0000);
        set_pins(6'b111011, 1'b1);
        check("R6 pin2 level", 32'(req_level), 32'd10);
        set_pins(6'b111111, 1'b1);
        check("R3 held after release", 32'(irq_pend), 32'h04);
        pulse_clr(6'b000100, 1'b0);
        check("R3 cleared", 32'(irq_pend), 32'h00);

        // R2 rising mode on pin 1
        wr_cfg(16'h0004);
        set_pins(6'b111101, 1'b1);
        check("R2 rise no set on fall", 32'(irq_pend[1]), 32'd0);
        set_pins(6'b111111, 1'b1);
        check("R2 rise set", 32'(irq_pend[1]), 32'd1);
        pulse_clr(6'b000010, 1'b0);

        // R4 level mode pin4 (10) and alt code 11
        wr_cfg(16'h0200);
        set_pins(6'b101111, 1'b1);
        check("R4 low pend", 32'(req_level), 32'd12);
        pulse_clr(6'b010000, 1'b0);
        check("R4 clr no effect", 32'(irq_pend[4]), 32'd1);
        set_pins(6'b111111, 1'b1);
        check("R4 release", 32'(irq_pend[4]), 32'd0);
        wr_cfg(16'h0300);
        set_pins(6'b101111, 1'b1);
        check("R2 code 11 level", 32'(irq_pend[4]), 32'd1);

        // R8 mask-all with NMI low; R9 NMI latch
        wr_cfg(16'h8300);
        set_pins(6'b101111, 1'b0);
        check("R8 masked level", 32'(req_level), 32'd0);
        check("R8 pend kept", 32'(irq_pend[4]), 32'd1);
        check("R9 nmi latched", 32'(nmi_req), 32'd1);
        set_pins(6'b101111, 1'b1);
        check("R8 unmasked", 32'(req_level), 32'd12);
        check("R9 nmi held", 32'(nmi_req), 32'd1);
        @(negedge clk) blk_bit = 1'b1;
        @(negedge clk);
        check("R9 blk masks", 32'(nmi_req), 32'd0);
        wr_cfg(16'hA300);
        check("R9 blk ok", 32'(nmi_req), 32'd1);
        @(negedge clk) begin blk_bit = 1'b0; standby = 1'b1; end
        @(negedge clk);
        check("R10 standby masks", 32'(nmi_req), 32'd0);
        check("R1 standby keeps cfg", 32'(cfg_rdata), 32'hA300);
        wr_cfg(16'h2300);
        check("R10 no mask-all", 32'(nmi_req), 32'd1);
        @(negedge clk) standby = 1'b0;
        pulse_clr(6'b000000, 1'b1);
        check("R9 nmi cleared", 32'(nmi_req), 32'd0);

        // R11 spare bit has no effect
        check_all("R11 before");
        wr_cfg(16'h3300);
        check_all("R11 after");

        // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int it = 0; it < 500; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5)
                set_pins(6'($urandom), ($urandom_range(0, 3) != 0));
            else if (op < 7)
                wr_cfg(16'($urandom));
            else if (op < 9)
                pulse_clr(6'($urandom), 1'($urandom));
            else begin
                @(negedge clk);
                blk_bit = 1'($urandom);
                standby = 1'($urandom);
                @(negedge clk);
            end
            check_all("R3 R4 R5 R6 R7 R8 R9 R10 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule